// File: doc/BRIEF.md
# Framed Synchronous Serial Port

A full-duplex serial port for exchanging 16-bit words with serial converters and codecs. It has a transmit path and a receive path. Each path holds a four-word FIFO on the processor side and a shift register on the line side. The processor pushes words through a write strobe and pops received words through a read strobe. It watches full and empty flags plus two level interrupts: one asks for more transmit data, the other reports received data.

The transmit bit clock and the transmit frame sync each come from one of two sources, chosen by a configuration input. Either the port generates them from the system clock or they arrive on pins. The receive bit clock and frame sync always arrive on pins. Every pin input passes through a two-flop synchronizer. All logic runs in the system clock domain and acts on the detected edges of the serial clocks.

Two framing modes are provided. In burst mode every word is preceded by its own frame sync. In continuous mode, words that are queued in time follow one another with no idle bit, and only the first word of the run carries a frame sync.

Top module: `ssp_port`

## Requirements
- R1: The transmit FIFO holds four words. `tx_full` is high while four unsent words are held, and a write made while `tx_full` is high is discarded.
- R2: Each transmit word leaves on `dout` most significant bit first, one bit per transmit clock period, and each bit changes only at a rising transmit clock edge. Words are delivered in the order written.
- R3: With `cfg_int_clk`=1 the port drives `sclk_tx_out` with `sclk_tx_oe`=1. Each half period lasts `cfg_half`+1 system clocks, so the fastest rate is half the system clock. The clock rests high while nothing is queued or in flight.
- R4: With `cfg_int_clk`=0, `sclk_tx_oe` is 0 and the transmit bits follow the edges of `sclk_tx_in`.
- R5: With `cfg_int_fs`=1 the port drives `fs_tx_out` high for the one bit period just before a word's first bit, changing it only on rising clock edges. With `cfg_int_fs`=0, `fs_tx_oe` is 0 and a queued word waits until `fs_tx_in` is high at a falling clock edge. The word's first bit then goes out on the next rising edge.
- R6: In burst mode (`cfg_cont`=0) a frame sync precedes every transmitted word.
- R7: In continuous mode (`cfg_cont`=1) a word queued when the previous one ends follows it with no gap and no new frame sync, so a run of words shows exactly one frame sync pulse.
- R8: The receiver samples `din` on falling edges of `sclk_rx`. When `fs_rx` is high at a falling edge, the next falling edge carries the most significant bit. After 16 bits the word enters the receive FIFO. In continuous mode the next word starts right away without a new frame sync.
- R9: `irq_tx` is high exactly when the transmit FIFO is empty. `irq_rx` is high exactly when the receive FIFO holds at least one word.
- R10: A received word that arrives while the receive FIFO is full is discarded and sets `rx_ovr`. `rx_ovr` then stays high until reset.
- R11: After reset both FIFOs are empty, `irq_tx`=1, `irq_rx`=0, `rx_ovr`=0, `sclk_tx_out`=1, `fs_tx_out`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_int_clk | input | 1 | 1: generate transmit clock, 0: take it from `sclk_tx_in` |
| cfg_int_fs | input | 1 | 1: generate transmit frame sync, 0: take it from `fs_tx_in` |
| cfg_cont | input | 1 | 1: continuous framing, 0: burst framing |
| cfg_half | input | DIV_W | Half period of the generated clock minus one, in system clocks |
| wr_en | input | 1 | Push `wr_data` into the transmit FIFO |
| wr_data | input | DATA_W | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rd_en | input | 1 | Pop the head of the receive FIFO |
| rd_data | output | DATA_W | Head of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| irq_tx | output | 1 | Transmit interrupt (FIFO empty) |
| irq_rx | output | 1 | Receive interrupt (FIFO not empty) |
| sclk_tx_in | input | 1 | External transmit bit clock |
| sclk_tx_out | output | 1 | Generated transmit bit clock |
| sclk_tx_oe | output | 1 | Output enable for the transmit clock pin |
| fs_tx_in | input | 1 | External transmit frame sync |
| fs_tx_out | output | 1 | Generated transmit frame sync |
| fs_tx_oe | output | 1 | Output enable for the transmit frame sync pin |
| dout | output | 1 | Serial transmit data |
| sclk_rx | input | 1 | Receive bit clock |
| fs_rx | input | 1 | Receive frame sync |
| din | input | 1 | Serial receive data |

## Verification
In internal clock mode the first clock action after a write is a falling edge, `cfg_half`+1 system clocks later. The frame sync rises on the rising edge after that, and the word lands in the receive FIFO after 17 more bit periods in burst mode, plus about three system clocks of synchronizer and edge-detect delay. The scoreboard therefore does not predict the arrival cycle. It predicts the order and value of words, and the monitor pops each word as soon as `rx_empty` falls. Counted checks (frame sync pulses, flag states) are sampled only after a wait that is well over the longest computed transfer time for the half period in use. The clock-period checks measure `sclk_tx_out` cycle by cycle on falling system clock edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SYNC  = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_int_clk,
  input  logic              cfg_int_fs,
  input  logic              cfg_cont,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              sclk_ext,
  input  logic              fs_ext,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              sclk_q,
  output logic              fs_q,
  output logic              dout_q
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  tx_state_t         state;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic              ext_d;
  logic run, int_tick, rise_evt, fall_evt;
  logic ending, chain, may_start, int_start, ext_start;

  // generated clock runs while work is pending, always parking high
  assign run      = (state != TX_IDLE) || !fifo_empty || !sclk_q;
  assign int_tick = cfg_int_clk && run && (div_cnt == cfg_half);
  assign rise_evt = cfg_int_clk ? (int_tick && !sclk_q) : (sclk_ext && !ext_d);
  assign fall_evt = cfg_int_clk ? (int_tick && sclk_q)  : (!sclk_ext && ext_d);

  assign ending    = rise_evt && (state == TX_SHIFT) && (bit_cnt == '0);
  assign chain     = ending && cfg_cont && !fifo_empty;
  assign may_start = rise_evt && ((state == TX_IDLE) || (ending && !chain));
  assign int_start = may_start && cfg_int_fs && !fifo_empty;
  assign ext_start = fall_evt && (state == TX_IDLE) && !cfg_int_fs && fs_ext && !fifo_empty;
  assign fifo_pop  = chain || int_start || ext_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sclk_q  <= 1'b1;
      ext_d   <= 1'b1;
    end else begin
      ext_d <= sclk_ext;
      if (cfg_int_clk && run) begin
        if (div_cnt == cfg_half) begin
          div_cnt <= '0;
          sclk_q  <= ~sclk_q;
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end else begin
        div_cnt <= '0;
        sclk_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      sr      <= '0;
      bit_cnt <= '0;
      fs_q    <= 1'b0;
      dout_q  <= 1'b0;
    end else if (ext_start) begin
      sr    <= fifo_head;
      state <= TX_SYNC;
    end else if (rise_evt) begin
      case (state)
        TX_SYNC: begin
          fs_q    <= 1'b0;
          dout_q  <= sr[DATA_W-1];
          sr      <= {sr[DATA_W-2:0], 1'b0};
          bit_cnt <= LAST_IDX;
          state   <= TX_SHIFT;
        end
        TX_SHIFT: begin
          if (bit_cnt != '0) begin
            dout_q  <= sr[DATA_W-1];
            sr      <= {sr[DATA_W-2:0], 1'b0};
            bit_cnt <= bit_cnt - CNT_W'(1);
          end else if (chain) begin
            dout_q  <= fifo_head[DATA_W-1];
            sr      <= {fifo_head[DATA_W-2:0], 1'b0};
            bit_cnt <= LAST_IDX;
          end else if (int_start) begin
            dout_q <= 1'b0;
            fs_q   <= 1'b1;
            sr     <= fifo_head;
            state  <= TX_SYNC;
          end else begin
            dout_q <= 1'b0;
            state  <= TX_IDLE;
          end
        end
        default: begin
          if (int_start) begin
            fs_q  <= 1'b1;
            sr    <= fifo_head;
            state <= TX_SYNC;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cont,
  input  logic              sclk_s,
  input  logic              fs_s,
  input  logic              din_s,
  output logic              push,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              active, sclk_d, fall;

  assign fall = sclk_d && !sclk_s;
  assign word = {sr, din_s};
  assign push = fall && !fs_s && active && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (fall) begin
        if (fs_s) begin
          active <= 1'b1;
          cnt    <= '0;
        end else if (active) begin
          sr <= word[DATA_W-2:0];
          if (cnt == LAST_IDX) begin
            cnt    <= '0;
            active <= cfg_cont;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_int_clk,
  input  logic              cfg_int_fs,
  input  logic              cfg_cont,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_ovr,
  output logic              irq_tx,
  output logic              irq_rx,
  input  logic              sclk_tx_in,
  output logic              sclk_tx_out,
  output logic              sclk_tx_oe,
  input  logic              fs_tx_in,
  output logic              fs_tx_out,
  output logic              fs_tx_oe,
  output logic              dout,
  input  logic              sclk_rx,
  input  logic              fs_rx,
  input  logic              din
);
  logic [4:0]        pins_s;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic              tx_pop, rx_push;

  // pin order: tx clock, tx sync, rx clock, rx sync, rx data
  ssp_sync #(.WIDTH(5), .STAGES(2), .RST_VAL(5'b10100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_tx_in, fs_tx_in, sclk_rx, fs_rx, din}),
    .q   (pins_s)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_en),
    .wdata (wr_data),
    .pop   (tx_pop),
    .head  (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  ssp_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .cfg_int_clk (cfg_int_clk),
    .cfg_int_fs  (cfg_int_fs),
    .cfg_cont    (cfg_cont),
    .cfg_half    (cfg_half),
    .sclk_ext    (pins_s[4]),
    .fs_ext      (pins_s[3]),
    .fifo_empty  (tx_empty),
    .fifo_head   (tx_head),
    .fifo_pop    (tx_pop),
    .sclk_q      (sclk_tx_out),
    .fs_q        (fs_tx_out),
    .dout_q      (dout)
  );

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .cfg_cont (cfg_cont),
    .sclk_s   (pins_s[2]),
    .fs_s     (pins_s[1]),
    .din_s    (pins_s[0]),
    .push     (rx_push),
    .word     (rx_word)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_push),
    .wdata (rx_word),
    .pop   (rd_en),
    .head  (rd_data),
    .empty (rx_empty),
    .full  (rx_full)
  );

  always_ff @(posedge clk) begin
    if (rst)                     rx_ovr <= 1'b0;
    else if (rx_push && rx_full) rx_ovr <= 1'b1;
  end

  assign irq_tx     = tx_empty;
  assign irq_rx     = !rx_empty;
  assign sclk_tx_oe = cfg_int_clk;
  assign fs_tx_oe   = cfg_int_fs;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
  input logic clk,
  input logic rst,
  input logic cfg_int_clk,
  input logic cfg_int_fs,
  input logic wr_en,
  input logic irq_tx,
  input logic rx_full,
  input logic rx_ovr,
  input logic dout,
  input logic sclk_tx_out,
  input logic fs_tx_out
);
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    rx_ovr |=> rx_ovr);

  p_ovr_needs_full_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr) |-> $past(rx_full));

  p_dout_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_int_clk && $past(cfg_int_clk) && !$stable(dout)) |-> $rose(sclk_tx_out));

  p_fs_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_int_clk && cfg_int_fs && $past(cfg_int_clk) && $past(cfg_int_fs)
     && !$stable(fs_tx_out)) |-> $rose(sclk_tx_out));

  p_irq_tx_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_tx) |-> $past(wr_en));
endmodule

bind ssp_port ssp_port_chk u_chk (.*);

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  logic        clk, rst;
  logic        cfg_int_clk, cfg_int_fs, cfg_cont;
  logic [7:0]  cfg_half;
  logic        wr_en, rd_en;
  logic [15:0] wr_data, rd_data;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_ovr, irq_tx, irq_rx;
  logic        sclk_tx_out, sclk_tx_oe, fs_tx_out, fs_tx_oe, dout;
  logic        ext_clk, ext_fs, ext_mode, ext_run, mon_en;
  logic        sclk_rx, fs_rx;

  int tests = 0, fails = 0, fs_rises = 0;
  logic [15:0] exp_q [$];

  assign sclk_rx = ext_mode ? ext_clk : sclk_tx_out;
  assign fs_rx   = ext_mode ? ext_fs  : fs_tx_out;

  ssp_port dut (
    .clk(clk), .rst(rst), .cfg_int_clk(cfg_int_clk), .cfg_int_fs(cfg_int_fs),
    .cfg_cont(cfg_cont), .cfg_half(cfg_half), .wr_en(wr_en), .wr_data(wr_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rd_en(rd_en), .rd_data(rd_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovr(rx_ovr), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .sclk_tx_in(ext_clk), .sclk_tx_out(sclk_tx_out),
    .sclk_tx_oe(sclk_tx_oe), .fs_tx_in(ext_fs), .fs_tx_out(fs_tx_out),
    .fs_tx_oe(fs_tx_oe), .dout(dout), .sclk_rx(sclk_rx), .fs_rx(fs_rx), .din(dout)
  );

  initial begin clk = 1'b0; forever #5 clk = ~clk; end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input bit keep);
    wr_en = 1'b1; wr_data = w;
    if (keep) exp_q.push_back(w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_pulse();
    @(posedge ext_clk);
    repeat (2) @(negedge clk);
    ext_fs = 1'b1;
    @(posedge ext_clk);
    repeat (2) @(negedge clk);
    ext_fs = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    p = sclk_tx_out;
    @(negedge clk);
    while (!(!p && sclk_tx_out)) begin p = sclk_tx_out; @(negedge clk); end
  endtask

  // monitor: pops the receive FIFO and compares against the scoreboard (R2 R8)
  initial begin
    rd_en = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_en) rd_en = 1'b0;
      else if (mon_en && !rx_empty) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected word", rd_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R2 R8 received word", rd_data, e);
        end
        rd_en = 1'b1;
      end
    end
  end

  initial begin
    logic p;
    p = 1'b0;
    forever begin
      @(negedge clk);
      if (fs_tx_out && !p) fs_rises++;
      p = fs_tx_out;
    end
  end

  initial begin
    ext_clk = 1'b1;
    forever begin
      repeat (8) @(negedge clk);
      if (ext_run || !ext_clk) ext_clk = ~ext_clk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int hi;
    logic a, b, c, d;
    rst = 1'b1; cfg_int_clk = 1'b1; cfg_int_fs = 1'b1; cfg_cont = 1'b0; cfg_half = 8'd3;
    wr_en = 1'b0; wr_data = '0; ext_fs = 1'b0; ext_mode = 1'b0; ext_run = 1'b0; mon_en = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state, R9 interrupts at reset
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R11 fifos empty", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk(irq_tx && !irq_rx, "R9 R11 irq at reset", {irq_tx, irq_rx}, 2'b10);
    chk(!rx_ovr && sclk_tx_out && !fs_tx_out && !dout, "R11 pins at reset",
        {rx_ovr, sclk_tx_out, fs_tx_out, dout}, 4'b0100);

    // R2: bit order on the line
    send(16'hA5C3, 1'b1);
    while (!fs_tx_out) @(negedge clk);
    while (fs_tx_out) @(negedge clk);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      logic q;
      q = sclk_tx_out;
      @(negedge clk);
      while (!(q && !sclk_tx_out)) begin q = sclk_tx_out; @(negedge clk); end
      w = {w[14:0], dout};
    end
    chk(w == 16'hA5C3, "R2 msb first on dout", w, 16'hA5C3);
    repeat (300) @(negedge clk);

    // R6 burst: one frame sync per word
    fs_rises = 0;
    send(16'h1234, 1'b1); send(16'hFFFF, 1'b1); send(16'h0001, 1'b1);
    repeat (1200) @(negedge clk);
    chk(fs_rises == 3, "R6 burst frame syncs", fs_rises, 3);
    chk(exp_q.size() == 0, "R2 burst words delivered", exp_q.size(), 0);

    // R7 continuous: one frame sync for the run
    cfg_cont = 1'b1; cfg_half = 8'd2; fs_rises = 0;
    send(16'hDEAD, 1'b1); send(16'hBEEF, 1'b1); send(16'h8000, 1'b1); send(16'h7FFE, 1'b1);
    repeat (1200) @(negedge clk);
    chk(fs_rises == 1, "R7 continuous single frame sync", fs_rises, 1);
    chk(exp_q.size() == 0, "R7 continuous words delivered", exp_q.size(), 0);
    cfg_cont = 1'b0;
    @(negedge clk);

    // R1 transmit FIFO depth and drop on full
    cfg_half = 8'd7;
    send(16'h0102, 1'b1); send(16'h0304, 1'b1); send(16'h0506, 1'b1); send(16'h0708, 1'b1);
    chk(tx_full, "R1 tx full after four", tx_full, 1);
    send(16'h0BAD, 1'b0);
    repeat (2000) @(negedge clk);
    chk(exp_q.size() == 0, "R1 four words sent, fifth dropped", exp_q.size(), 0);
    chk(irq_tx && tx_empty, "R9 irq_tx when drained", irq_tx, 1);

    // R10 receive overrun
    cfg_half = 8'd1; mon_en = 1'b0;
    repeat (3) @(negedge clk);
    send(16'h1111, 1'b1); send(16'h2222, 1'b1); send(16'h3333, 1'b1);
    repeat (300) @(negedge clk);
    chk(irq_rx && !rx_ovr, "R9 irq_rx with data held", {irq_rx, rx_ovr}, 2'b10);
    send(16'h4444, 1'b1); send(16'h5555, 1'b0); send(16'h6666, 1'b0);
    repeat (400) @(negedge clk);
    chk(rx_full, "R10 rx full", rx_full, 1);
    chk(rx_ovr, "R10 overrun set", rx_ovr, 1);
    mon_en = 1'b1;
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R10 first four kept", exp_q.size(), 0);
    chk(rx_ovr && !irq_rx, "R10 overrun sticky after drain", {rx_ovr, irq_rx}, 2'b10);

    // R3 generated clock rate
    cfg_half = 8'd0;
    send(16'h5A5A, 1'b1);
    wait_rise();
    a = sclk_tx_out; @(negedge clk); b = sclk_tx_out; @(negedge clk);
    c = sclk_tx_out; @(negedge clk); d = sclk_tx_out;
    chk({a, b, c, d} == 4'b1010 && sclk_tx_oe, "R3 half system clock rate", {a, b, c, d}, 4'b1010);
    repeat (200) @(negedge clk);
    cfg_half = 8'd3;
    send(16'hC3C3, 1'b1);
    wait_rise();
    hi = 0;
    while (sclk_tx_out) begin hi++; @(negedge clk); end
    chk(hi == 4, "R3 high phase cfg_half+1", hi, 4);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R3 words delivered", exp_q.size(), 0);

    // R4 R5 external clock and frame sync
    cfg_int_clk = 1'b0; cfg_int_fs = 1'b0; ext_mode = 1'b1; ext_run = 1'b1;
    @(negedge clk);
    chk(!sclk_tx_oe && !fs_tx_oe, "R4 R5 pin directions", {sclk_tx_oe, fs_tx_oe}, 2'b00);
    send(16'h3C5A, 1'b1);
    repeat (200) @(negedge clk);
    chk(!tx_empty && rx_empty, "R5 word held until frame sync", {tx_empty, rx_empty}, 2'b01);
    ext_pulse();
    repeat (600) @(negedge clk);
    chk(exp_q.size() == 0, "R4 external clock word", exp_q.size(), 0);
    send(16'hC001, 1'b1);
    ext_pulse();
    repeat (600) @(negedge clk);
    chk(exp_q.size() == 0, "R4 R5 second external word", exp_q.size(), 0);
    ext_run = 1'b0;
    repeat (40) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule